// File: doc/BRIEF.md
# Three-Wire Synthesizer Control Port

This block is the write-only control port of a dual fractional-N synthesizer. A host drives three wires (serial clock, serial data and an active-low select) plus an optional fourth pin reserved for modulation samples. All wires are first brought into the system clock domain. Bits are then shifted in on the rising edges of the serial clock, and the complete stream is acted on when the select line returns high.

A stream of sixteen or more bits is an addressed write: a 4-bit address followed by 12 data bits. A stream of 2 to 12 bits carries no address and is a modulation sample. The sample goes to the modulation-data output, sign-extended, together with its length and a one-cycle strobe. The divide-ratio registers are double-buffered. A new main or auxiliary ratio reaches the active outputs only when the last register of its group is written, unless the synthesizer runs in integer mode. A test multiplexer drives one of several internal clocks, or an echo of the serial bits, onto a shared output that can be switched off.

Top module: `synth_ctl_port`

## Requirements
- R1: While select is low, each rising serial-clock edge shifts in one data bit, most significant first. When select rises after exactly 16 bits, bits 15:12 form the address and bits 11:0 form the data that loads that register.
- R2: If more than 16 bits are shifted in, only the last 16 form the frame.
- R3: A stream of 2 to 12 bits is a modulation sample. When it ends, mod_data_o takes the value sign-extended from its top bit, mod_len_o takes the bit count, and mod_strobe_o pulses for one cycle. Register 8 bit 0 set to 1 takes the sample bits from mod_in_i instead of sdata_i.
- R4: Streams of 0, 1, 13, 14 or 15 bits change nothing. With register 8 bit 1 set, streams of 2 to 12 bits also change nothing.
- R5: After reset, registers 0 and 3 and the active main and auxiliary integer ratios hold 6. Every other register and output value is 0, mux_oe_o is 1, and the mux drives xo_ref_i.
- R6: With register 7 bit 3 = 0 and bit 2 = 0, writes to register 0 (integer) and register 2 (fraction low 8 bits) are only staged. A write to register 1 commits main_int_o from register 0 and sets main_frac_o = {new[9:0], reg2[7:0]}.
- R7: With register 7 bit 3 = 1, a write to register 1 alone commits the ratio: main_frac_o is new[9:0] sign-extended to 18 bits, and main_int_o is taken from register 0.
- R8: A write to register 4 commits aux_int_o from register 3 and sets aux_frac_o = new[9:0]. With register 7 bit 2 (main) or bit 5 (auxiliary) set to 1, a write to register 0 or register 3 reaches main_int_o or aux_int_o at once.
- R9: Register 7 bits 8:6 select the mux source: 0 xo_ref_i, 1 aux_ref_i, 2 main_ref_i, 3 aux_pd_i, 4 main_pd_i, 5 serial echo, 6 test_sig_i, 7 constant 0. Register 7 bit 9 = 1 drives mux_oe_o low and mux_o to 0.
- R10: In echo mode, the echoed bit changes only on a falling serial-clock edge while select is low. It then takes the bit captured on the preceding rising edge.
- R11: Serial-clock edges while select is high have no effect. Addressed writes to addresses 10 to 15 change nothing.
- R12: An addressed write to address 9 sets mod_data_o to the 12 data bits and mod_len_o to 12, and pulses mod_strobe_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock (asynchronous) |
| sdata_i | input | 1 | Serial data |
| csn_i | input | 1 | Active-low frame select |
| mod_in_i | input | 1 | Alternate modulation sample input |
| xo_ref_i | input | 1 | Oscillator reference for the mux |
| aux_ref_i | input | 1 | Divided auxiliary reference for the mux |
| main_ref_i | input | 1 | Divided main reference for the mux |
| aux_pd_i | input | 1 | Auxiliary phase-detector clock for the mux |
| main_pd_i | input | 1 | Main phase-detector clock for the mux |
| test_sig_i | input | 1 | Test signal for the mux |
| main_int_o | output | 9 | Active main integer ratio index |
| main_frac_o | output | 18 | Active main fraction (two's complement) |
| aux_int_o | output | 9 | Active auxiliary integer ratio index |
| aux_frac_o | output | 10 | Active auxiliary fraction (two's complement) |
| ref_div_o | output | 12 | Register 5, reference divider indices |
| pd_ctl_o | output | 12 | Register 6, phase detector control |
| pwr_ctl_o | output | 12 | Register 7, power, mode and mux control |
| mod_ctl_o | output | 12 | Register 8, modulation control |
| mod_data_o | output | 12 | Last modulation sample, sign-extended |
| mod_len_o | output | 4 | Bit count of the last modulation sample |
| mod_strobe_o | output | 1 | One-cycle pulse on each new sample |
| mux_o | output | 1 | Test multiplexer output |
| mux_oe_o | output | 1 | Mux output enable |

## Verification
The bench targets the length boundaries that decide a frame's fate. It sends streams of 1, 2, 12, 14, 16 and 20 bits: a design that counted off by one would turn a 13-to-15-bit stream into a sample, or drop a 2-bit sample. It checks ratio staging across both fraction widths and integer mode. A design that committed early would move main_int_o before the high-fraction write, and one with the wrong sign extension would give the wrong 18-bit fraction for a negative 10-bit value. The echo output is sampled between a rising and a falling serial edge to catch a design that updates on the wrong edge. Writes to unused addresses and clock toggles while select is high are checked for having no visible effect.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 12;
    localparam int FRAME_W   = ADDR_W + DATA_W;
    localparam int NREG      = 10;
    localparam int CNT_W     = $clog2(FRAME_W + 1);
    localparam int LEN_W     = $clog2(DATA_W + 1);
    localparam int MIN_SHORT = 2;
    localparam int DIV_W     = 9;
    localparam int FRAC_HI_W = 10;
    localparam int FRAC_LO_W = 8;
    localparam int FRAC_W    = FRAC_HI_W + FRAC_LO_W;
    localparam int MUX_SEL_W = 3;

    localparam logic [DATA_W-1:0] DIV_RST = 12'h006;

    // bit positions inside the power/mode register (7)
    localparam int B_MAIN_INTN   = 2;
    localparam int B_MAIN_NARROW = 3;
    localparam int B_AUX_INTN    = 5;
    localparam int B_MUX_LO      = 6;
    localparam int B_MUX_OFF     = 9;
    // bit positions inside the modulation control register (8)
    localparam int B_MOD_PIN     = 0;
    localparam int B_SHORT_OFF   = 1;

    typedef enum logic [ADDR_W-1:0] {
        A_MAIN_INT  = 4'd0,
        A_MAIN_HI   = 4'd1,
        A_MAIN_LO   = 4'd2,
        A_AUX_INT   = 4'd3,
        A_AUX_FRAC  = 4'd4,
        A_REFDIV    = 4'd5,
        A_PDCTL     = 4'd6,
        A_PWRCTL    = 4'd7,
        A_MODCTL    = 4'd8,
        A_MODDAT    = 4'd9
    } reg_addr_e;

    typedef enum logic [1:0] {
        FK_NONE = 2'd0,
        FK_ADDR = 2'd1,
        FK_MOD  = 2'd2
    } frame_kind_e;

    typedef struct packed {
        frame_kind_e         kind;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
        logic [LEN_W-1:0]    len;
    } frame_t;

    typedef enum logic [MUX_SEL_W-1:0] {
        MX_REF     = 3'd0,
        MX_AUXREF  = 3'd1,
        MX_MAINREF = 3'd2,
        MX_AUXPD   = 3'd3,
        MX_MAINPD  = 3'd4,
        MX_ECHO    = 3'd5,
        MX_TEST    = 3'd6,
        MX_LOW     = 3'd7
    } mux_sel_e;

    // sign-extend the low n bits of v to the full data width
    function automatic logic [DATA_W-1:0] sext_short(input logic [DATA_W-1:0] v,
                                                     input logic [CNT_W-1:0] n);
        logic [DATA_W-1:0] r;
        int top;
        top = int'(n) - 1;
        if (top < 0) top = 0;
        if (top > DATA_W - 1) top = DATA_W - 1;
        for (int i = 0; i < DATA_W; i++)
            r[i] = (i <= top) ? v[i] : v[top];
        return r;
    endfunction

    function automatic logic is_short(input logic [CNT_W-1:0] n);
        return (n >= CNT_W'(MIN_SHORT)) && (n <= CNT_W'(DATA_W));
    endfunction

endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
    parameter int W = 4,
    parameter int DEPTH = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d;
    end

    for (genvar k = 1; k < DEPTH; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[k] <= RST_VAL;
            else     stg[k] <= stg[k-1];
        end
    end

    assign q = stg[DEPTH-1];
endmodule

// File: rtl/sctl_deframer.sv
module sctl_deframer
    import sctl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sclk_s,
    input  logic   sdat_s,
    input  logic   mod_s,
    input  logic   csn_s,
    input  logic   use_mod_pin,
    input  logic   short_off,
    output frame_t frame_o,
    output logic   sclk_fall_o,
    output logic   cs_low_o,
    output logic   last_bit_o
);
    logic [FRAME_W-1:0] sh;
    logic [DATA_W-1:0]  msh;
    logic [CNT_W-1:0]   cnt;
    logic               sclk_d, cs_d;
    logic               rise, cs_fall, cs_rise;
    frame_t             nxt, frame_q;
    logic [DATA_W-1:0]  short_src;

    assign rise    = sclk_s & ~sclk_d;
    assign cs_fall = ~csn_s & cs_d;
    assign cs_rise = csn_s & ~cs_d;

    assign short_src = use_mod_pin ? msh : sh[DATA_W-1:0];

    always_comb begin
        nxt = '0;
        nxt.kind = FK_NONE;
        if (cs_rise) begin
            if (cnt >= CNT_W'(FRAME_W)) begin
                nxt.kind = FK_ADDR;
                nxt.addr = sh[FRAME_W-1:DATA_W];
                nxt.data = sh[DATA_W-1:0];
                nxt.len  = LEN_W'(DATA_W);
            end else if (is_short(cnt) && !short_off) begin
                nxt.kind = FK_MOD;
                nxt.data = sext_short(short_src, cnt);
                nxt.len  = LEN_W'(cnt);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '0;
            msh     <= '0;
            cnt     <= '0;
            sclk_d  <= 1'b0;
            cs_d    <= 1'b1;
            frame_q <= '0;
        end else begin
            sclk_d  <= sclk_s;
            cs_d    <= csn_s;
            frame_q <= nxt;
            if (cs_fall) begin
                cnt <= '0;
            end else if (!csn_s && rise) begin
                sh  <= {sh[FRAME_W-2:0], sdat_s};
                msh <= {msh[DATA_W-2:0], mod_s};
                if (cnt < CNT_W'(FRAME_W)) cnt <= cnt + 1'b1;
            end
        end
    end

    assign frame_o     = frame_q;
    assign sclk_fall_o = ~sclk_s & sclk_d;
    assign cs_low_o    = ~csn_s;
    assign last_bit_o  = sh[0];
endmodule

// File: rtl/sctl_regbank.sv
module sctl_regbank
    import sctl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  frame_t               frm,
    output logic [DIV_W-1:0]     main_int_o,
    output logic [FRAC_W-1:0]    main_frac_o,
    output logic [DIV_W-1:0]     aux_int_o,
    output logic [FRAC_HI_W-1:0] aux_frac_o,
    output logic [DATA_W-1:0]    ref_div_o,
    output logic [DATA_W-1:0]    pd_ctl_o,
    output logic [DATA_W-1:0]    pwr_ctl_o,
    output logic [DATA_W-1:0]    mod_ctl_o,
    output logic [DATA_W-1:0]    mod_data_o,
    output logic [LEN_W-1:0]     mod_len_o,
    output logic                 mod_strobe_o
);
    logic [DATA_W-1:0] rf [NREG];
    logic main_intn, main_narrow, aux_intn;
    logic [FRAC_HI_W-1:0] hi_new;

    assign main_intn   = rf[A_PWRCTL][B_MAIN_INTN];
    assign main_narrow = rf[A_PWRCTL][B_MAIN_NARROW];
    assign aux_intn    = rf[A_PWRCTL][B_AUX_INTN];
    assign hi_new      = frm.data[FRAC_HI_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++)
                rf[i] <= (i == int'(A_MAIN_INT) || i == int'(A_AUX_INT)) ? DIV_RST : '0;
            main_int_o   <= DIV_RST[DIV_W-1:0];
            aux_int_o    <= DIV_RST[DIV_W-1:0];
            main_frac_o  <= '0;
            aux_frac_o   <= '0;
            mod_data_o   <= '0;
            mod_len_o    <= '0;
            mod_strobe_o <= 1'b0;
        end else begin
            mod_strobe_o <= 1'b0;
            case (frm.kind)
                FK_MOD: begin
                    mod_data_o   <= frm.data;
                    mod_len_o    <= frm.len;
                    mod_strobe_o <= 1'b1;
                end
                FK_ADDR: begin
                    if (int'(frm.addr) < NREG) begin
                        rf[frm.addr] <= frm.data;
                        case (reg_addr_e'(frm.addr))
                            A_MAIN_INT: if (main_intn) main_int_o <= frm.data[DIV_W-1:0];
                            A_MAIN_HI: begin
                                main_int_o <= rf[A_MAIN_INT][DIV_W-1:0];
                                if (main_narrow)
                                    main_frac_o <= {{(FRAC_W-FRAC_HI_W){hi_new[FRAC_HI_W-1]}}, hi_new};
                                else
                                    main_frac_o <= {hi_new, rf[A_MAIN_LO][FRAC_LO_W-1:0]};
                            end
                            A_AUX_INT: if (aux_intn) aux_int_o <= frm.data[DIV_W-1:0];
                            A_AUX_FRAC: begin
                                aux_int_o  <= rf[A_AUX_INT][DIV_W-1:0];
                                aux_frac_o <= hi_new;
                            end
                            A_MODDAT: begin
                                mod_data_o   <= frm.data;
                                mod_len_o    <= LEN_W'(DATA_W);
                                mod_strobe_o <= 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
                default: ;
            endcase
        end
    end

    assign ref_div_o = rf[A_REFDIV];
    assign pd_ctl_o  = rf[A_PDCTL];
    assign pwr_ctl_o = rf[A_PWRCTL];
    assign mod_ctl_o = rf[A_MODCTL];
endmodule

// File: rtl/sctl_testmux.sv
module sctl_testmux
    import sctl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [MUX_SEL_W-1:0] sel,
    input  logic                 off,
    input  logic                 xo_ref,
    input  logic                 aux_ref,
    input  logic                 main_ref,
    input  logic                 aux_pd,
    input  logic                 main_pd,
    input  logic                 test_sig,
    input  logic                 sclk_fall,
    input  logic                 cs_low,
    input  logic                 last_bit,
    output logic                 mux_o,
    output logic                 mux_oe_o
);
    localparam int NSRC = 1 << MUX_SEL_W;
    logic            echo_q;
    logic [NSRC-1:0] src;

    always_ff @(posedge clk) begin
        if (rst)                      echo_q <= 1'b0;
        else if (sclk_fall && cs_low) echo_q <= last_bit;
    end

    always_comb begin
        src = '0;
        src[MX_REF]     = xo_ref;
        src[MX_AUXREF]  = aux_ref;
        src[MX_MAINREF] = main_ref;
        src[MX_AUXPD]   = aux_pd;
        src[MX_MAINPD]  = main_pd;
        src[MX_ECHO]    = echo_q;
        src[MX_TEST]    = test_sig;
        src[MX_LOW]     = 1'b0;
    end

    assign mux_oe_o = ~off;
    assign mux_o    = off ? 1'b0 : src[sel];
endmodule

// File: rtl/synth_ctl_port.sv
module synth_ctl_port
    import sctl_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sclk_i,
    input  logic                 sdata_i,
    input  logic                 csn_i,
    input  logic                 mod_in_i,
    input  logic                 xo_ref_i,
    input  logic                 aux_ref_i,
    input  logic                 main_ref_i,
    input  logic                 aux_pd_i,
    input  logic                 main_pd_i,
    input  logic                 test_sig_i,
    output logic [8:0]           main_int_o,
    output logic [17:0]          main_frac_o,
    output logic [8:0]           aux_int_o,
    output logic [9:0]           aux_frac_o,
    output logic [11:0]          ref_div_o,
    output logic [11:0]          pd_ctl_o,
    output logic [11:0]          pwr_ctl_o,
    output logic [11:0]          mod_ctl_o,
    output logic [11:0]          mod_data_o,
    output logic [3:0]           mod_len_o,
    output logic                 mod_strobe_o,
    output logic                 mux_o,
    output logic                 mux_oe_o
);
    logic [3:0] raw, syn;
    frame_t     frame;
    logic       frm_vld, sclk_fall, cs_low, last_bit;

    assign raw = {csn_i, sclk_i, sdata_i, mod_in_i};

    sctl_sync #(.W(4), .DEPTH(SYNC_DEPTH), .RST_VAL(4'b1000)) i_sync (
        .clk(clk), .rst(rst), .d(raw), .q(syn)
    );

    sctl_deframer i_deframer (
        .clk(clk), .rst(rst),
        .sclk_s(syn[2]), .sdat_s(syn[1]), .mod_s(syn[0]), .csn_s(syn[3]),
        .use_mod_pin(mod_ctl_o[B_MOD_PIN]), .short_off(mod_ctl_o[B_SHORT_OFF]),
        .frame_o(frame), .sclk_fall_o(sclk_fall), .cs_low_o(cs_low),
        .last_bit_o(last_bit)
    );

    assign frm_vld = (frame.kind != FK_NONE);

    sctl_regbank i_regbank (
        .clk(clk), .rst(rst), .frm(frame),
        .main_int_o(main_int_o), .main_frac_o(main_frac_o),
        .aux_int_o(aux_int_o), .aux_frac_o(aux_frac_o),
        .ref_div_o(ref_div_o), .pd_ctl_o(pd_ctl_o),
        .pwr_ctl_o(pwr_ctl_o), .mod_ctl_o(mod_ctl_o),
        .mod_data_o(mod_data_o), .mod_len_o(mod_len_o),
        .mod_strobe_o(mod_strobe_o)
    );

    sctl_testmux i_testmux (
        .clk(clk), .rst(rst),
        .sel(pwr_ctl_o[B_MUX_LO +: MUX_SEL_W]), .off(pwr_ctl_o[B_MUX_OFF]),
        .xo_ref(xo_ref_i), .aux_ref(aux_ref_i), .main_ref(main_ref_i),
        .aux_pd(aux_pd_i), .main_pd(main_pd_i), .test_sig(test_sig_i),
        .sclk_fall(sclk_fall), .cs_low(cs_low), .last_bit(last_bit),
        .mux_o(mux_o), .mux_oe_o(mux_oe_o)
    );
endmodule

// File: rtl/synth_ctl_port_chk.sv
module synth_ctl_port_chk
    import sctl_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        frm_vld,
    input logic        sclk_fall,
    input logic [8:0]  main_int_o,
    input logic [17:0] main_frac_o,
    input logic [8:0]  aux_int_o,
    input logic [9:0]  aux_frac_o,
    input logic [11:0] pwr_ctl_o,
    input logic [3:0]  mod_len_o,
    input logic        mod_strobe_o,
    input logic        mux_o,
    input logic        mux_oe_o
);
    // R3: a strobed sample always has a legal length
    p_len_range_r3: assert property (@(posedge clk) disable iff (rst)
        mod_strobe_o |-> (mod_len_o >= 4'(MIN_SHORT) && mod_len_o <= 4'(DATA_W)));

    // R4: a strobe only follows a recognised frame
    p_strobe_cause_r4: assert property (@(posedge clk) disable iff (rst)
        mod_strobe_o |-> $past(frm_vld));

    // R5: integer ratios leave reset at 6
    p_reset_ratio_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (main_int_o == 9'd6 && aux_int_o == 9'd6));

    // R6: main fraction only moves right after a frame
    p_main_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(frm_vld) |-> $stable(main_frac_o));

    // R8: auxiliary fraction only moves right after a frame
    p_aux_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(frm_vld) |-> $stable(aux_frac_o));

    // R10: echo output moves only after a falling serial edge
    p_echo_edge_r10: assert property (@(posedge clk) disable iff (rst)
        (pwr_ctl_o[B_MUX_LO +: MUX_SEL_W] == MX_ECHO && mux_oe_o &&
         $past(pwr_ctl_o[B_MUX_LO +: MUX_SEL_W]) == MX_ECHO && $past(mux_oe_o) &&
         !$past(sclk_fall)) |-> $stable(mux_o));
endmodule

bind synth_ctl_port synth_ctl_port_chk i_chk (
    .clk(clk), .rst(rst), .frm_vld(frm_vld), .sclk_fall(sclk_fall),
    .main_int_o(main_int_o), .main_frac_o(main_frac_o),
    .aux_int_o(aux_int_o), .aux_frac_o(aux_frac_o),
    .pwr_ctl_o(pwr_ctl_o), .mod_len_o(mod_len_o),
    .mod_strobe_o(mod_strobe_o), .mux_o(mux_o), .mux_oe_o(mux_oe_o)
);

// File: tb/test_synth_ctl_port.sv
module test_synth_ctl_port;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, sclk, sdata, csn, mod_in;
    logic xo_ref, aux_ref, main_ref, aux_pd, main_pd, test_sig;
    logic [8:0]  main_int;
    logic [17:0] main_frac;
    logic [8:0]  aux_int;
    logic [9:0]  aux_frac;
    logic [11:0] ref_div, pd_ctl, pwr_ctl, mod_ctl, mod_data;
    logic [3:0]  mod_len;
    logic        mod_strobe, mux, mux_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    synth_ctl_port i_synth_ctl_port (
        .clk(clk), .rst(rst), .sclk_i(sclk), .sdata_i(sdata), .csn_i(csn),
        .mod_in_i(mod_in), .xo_ref_i(xo_ref), .aux_ref_i(aux_ref),
        .main_ref_i(main_ref), .aux_pd_i(aux_pd), .main_pd_i(main_pd),
        .test_sig_i(test_sig), .main_int_o(main_int), .main_frac_o(main_frac),
        .aux_int_o(aux_int), .aux_frac_o(aux_frac), .ref_div_o(ref_div),
        .pd_ctl_o(pd_ctl), .pwr_ctl_o(pwr_ctl), .mod_ctl_o(mod_ctl),
        .mod_data_o(mod_data), .mod_len_o(mod_len), .mod_strobe_o(mod_strobe),
        .mux_o(mux), .mux_oe_o(mux_oe)
    );

    // {req[63:56], len[55:48], bits[47:24], chk[23:20], expected[19:0]}
    // chk: 0 ref_div 1 pd_ctl 2 pwr_ctl 3 mod_ctl 4 mod_data 5 main_int
    //      6 main_frac 7 aux_int 8 aux_frac 9 mod_len ; len 0 = check only
    localparam int NV = 29;
    localparam logic [63:0] VEC [NV] = '{
        {8'd1,  8'd16, 24'h00501F, 4'd0, 20'h0001F},  // R1 reg5
        {8'd1,  8'd16, 24'h006ABC, 4'd1, 20'h00ABC},  // R1 reg6
        {8'd6,  8'd16, 24'h00000D, 4'd5, 20'h00006},  // R6 staged int
        {8'd6,  8'd16, 24'h002098, 4'd6, 20'h00000},  // R6 staged low
        {8'd6,  8'd16, 24'h00107D, 4'd6, 20'h07D98},  // R6 commit
        {8'd6,  8'd0,  24'h000000, 4'd5, 20'h0000D},  // R6 int committed
        {8'd8,  8'd16, 24'h003012, 4'd7, 20'h00006},  // R8 staged aux int
        {8'd8,  8'd16, 24'h0043FF, 4'd8, 20'h003FF},  // R8 aux commit
        {8'd8,  8'd0,  24'h000000, 4'd7, 20'h00012},  // R8 aux int committed
        {8'd3,  8'd5,  24'h000016, 4'd4, 20'h00FF6},  // R3 5-bit negative
        {8'd3,  8'd0,  24'h000000, 4'd9, 20'h00005},  // R3 length
        {8'd3,  8'd2,  24'h000001, 4'd4, 20'h00001},  // R3 2-bit minimum
        {8'd3,  8'd12, 24'h000800, 4'd4, 20'h00800},  // R3 12-bit maximum
        {8'd4,  8'd14, 24'h001234, 4'd4, 20'h00800},  // R4 14 bits dropped
        {8'd4,  8'd1,  24'h000001, 4'd4, 20'h00800},  // R4 1 bit dropped
        {8'd2,  8'd20, 24'h0F5003, 4'd0, 20'h00003},  // R2 last 16 of 20
        {8'd11, 8'd16, 24'h00A555, 4'd0, 20'h00003},  // R11 address 10
        {8'd12, 8'd16, 24'h0097A5, 4'd4, 20'h007A5},  // R12 addressed sample
        {8'd12, 8'd0,  24'h000000, 4'd9, 20'h0000C},  // R12 length 12
        {8'd7,  8'd16, 24'h007008, 4'd2, 20'h00008},  // R7 narrow mode on
        {8'd7,  8'd16, 24'h000010, 4'd5, 20'h0000D},  // R7 int staged
        {8'd7,  8'd16, 24'h001334, 4'd6, 20'h3FF34},  // R7 sign-extended commit
        {8'd7,  8'd0,  24'h000000, 4'd5, 20'h00010},  // R7 int committed
        {8'd8,  8'd16, 24'h007024, 4'd2, 20'h00024},  // R8 integer modes
        {8'd8,  8'd16, 24'h0001FF, 4'd5, 20'h001FF},  // R8 main immediate
        {8'd8,  8'd16, 24'h003055, 4'd7, 20'h00055},  // R8 aux immediate
        {8'd4,  8'd16, 24'h008002, 4'd3, 20'h00002},  // R4 short frames off
        {8'd4,  8'd6,  24'h000015, 4'd4, 20'h007A5},  // R4 sample dropped
        {8'd3,  8'd16, 24'h008001, 4'd3, 20'h00001}   // R3 alternate pin
    };

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input int req, input string what,
                         input logic [19:0] act, input logic [19:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic send(input int n, input logic [23:0] bits, input logic [11:0] mbits);
        csn = 1'b0;
        idle(3);
        for (int i = n - 1; i >= 0; i--) begin
            sdata  = bits[i];
            mod_in = (i < 12) ? mbits[i % 12] : 1'b0;
            idle(3);
            sclk = 1'b1;
            idle(3);
            sclk = 1'b0;
        end
        idle(3);
        csn = 1'b1;
        idle(10);
    endtask

    task automatic wr(input logic [3:0] a, input logic [11:0] d);
        send(16, {8'h00, a, d}, 12'h000);
    endtask

    function automatic logic [19:0] pick(input logic [3:0] c);
        case (c)
            4'd0: return 20'(ref_div);
            4'd1: return 20'(pd_ctl);
            4'd2: return 20'(pwr_ctl);
            4'd3: return 20'(mod_ctl);
            4'd4: return 20'(mod_data);
            4'd5: return 20'(main_int);
            4'd6: return 20'(main_frac);
            4'd7: return 20'(aux_int);
            4'd8: return 20'(aux_frac);
            default: return 20'(mod_len);
        endcase
    endfunction

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; sclk = 1'b0; sdata = 1'b0; csn = 1'b1; mod_in = 1'b0;
        xo_ref = 1'b1; aux_ref = 1'b0; main_ref = 1'b1;
        aux_pd = 1'b0; main_pd = 1'b1; test_sig = 1'b0;
        idle(5);
        rst = 1'b0;
        idle(3);

        // R5 reset state
        check(5, "main int reset", 20'(main_int), 20'h6);
        check(5, "aux int reset", 20'(aux_int), 20'h6);
        check(5, "main frac reset", 20'(main_frac), 20'h0);
        check(5, "pwr ctl reset", 20'(pwr_ctl), 20'h0);
        check(5, "mod data reset", 20'(mod_data), 20'h0);
        check(5, "mux oe reset", 20'(mux_oe), 20'h1);
        check(5, "mux follows ref", 20'(mux), 20'(xo_ref));

        for (int v = 0; v < NV; v++) begin
            if (VEC[v][55:48] != 8'd0)
                send(int'(VEC[v][55:48]), VEC[v][47:24], 12'h000);
            check(int'(VEC[v][63:56]), $sformatf("vector %0d", v),
                  pick(VEC[v][23:20]), VEC[v][19:0]);
        end

        // R3 alternate pin carries the sample (mod_ctl = 1 now)
        send(4, 24'h00000A, 12'h005);
        check(3, "alt pin sample", 20'(mod_data), 20'h005);
        wr(4'd8, 12'h000);
        send(3, 24'h000003, 12'hFFF);
        check(3, "data pin sample", 20'(mod_data), 20'h003);

        // R11 clock toggles with select high
        for (int k = 0; k < 6; k++) begin
            sdata = k[0];
            sclk = 1'b1; idle(3);
            sclk = 1'b0; idle(3);
        end
        idle(6);
        check(11, "ref div after idle toggles", 20'(ref_div), 20'h003);
        check(11, "mod data after idle toggles", 20'(mod_data), 20'h003);
        wr(4'd6, 12'h123);
        check(11, "frame after idle toggles", 20'(pd_ctl), 20'h123);

        // R9 mux source selection, both input polarities
        for (int pol = 0; pol < 2; pol++) begin
            xo_ref = pol[0]; aux_ref = ~pol[0]; main_ref = pol[0];
            aux_pd = ~pol[0]; main_pd = pol[0]; test_sig = ~pol[0];
            for (int s = 0; s < 8; s++) begin
                logic e;
                if (s == 5) continue;
                wr(4'd7, 12'(s << 6));
                case (s)
                    0: e = xo_ref;
                    1: e = aux_ref;
                    2: e = main_ref;
                    3: e = aux_pd;
                    4: e = main_pd;
                    6: e = test_sig;
                    default: e = 1'b0;
                endcase
                check(9, $sformatf("mux sel %0d", s), 20'(mux), 20'(e));
            end
        end
        wr(4'd7, 12'h200);
        check(9, "mux disabled oe", 20'(mux_oe), 20'h0);
        check(9, "mux disabled level", 20'(mux), 20'h0);

        // R10 echo follows falling edges
        wr(4'd7, 12'h140);
        check(9, "mux enabled", 20'(mux_oe), 20'h1);
        csn = 1'b0;
        idle(3);
        begin
            logic [3:0] pat;
            logic prev;
            pat = 4'b1011;
            prev = mux;
            for (int i = 3; i >= 0; i--) begin
                sdata = pat[i];
                idle(3);
                sclk = 1'b1;
                idle(5);
                check(10, "echo before fall", 20'(mux), 20'(prev));
                sclk = 1'b0;
                idle(6);
                check(10, "echo after fall", 20'(mux), 20'(pat[i]));
                prev = pat[i];
            end
        end
        csn = 1'b1;
        idle(10);

        done = 1;
        summary();
        $finish;
    end
endmodule